// File: doc/BRIEF.md
# Event Timer with Periodic Comparators

This block is a memory-mapped event timer. A 64-bit main counter advances once per clock while a global run bit is set. Comparator channels (two by default) watch that counter. When a channel's comparator equals the counter, the channel emits a one-cycle interrupt pulse. Each channel works either one-shot or periodic. In periodic mode it adds a programmed period to its comparator on every match.

Software reaches the block through a word-addressed register port. Writes are synchronous and reads are combinational. A read-only identification word reports the channel count and legacy steering support, and a second read-only word gives the tick period in femtoseconds. Each channel's pulse goes to one of several interrupt lines chosen by its route field. When legacy steering is on, channels 0 and 1 go to two dedicated outputs instead.

A set-value bit in a channel's configuration changes the meaning of the next two comparator writes. The first still loads the comparator. The second loads the period.

Top module: `evt_timer`

## Requirements
- R1: After reset the register at word 0 reads 0x00000101 (bits 4:0 = channels minus one, bit 8 = legacy steering supported), word 1 reads the tick period in femtoseconds (default 5000000), the global configuration word 2 reads 0, the counter reads 0, and all interrupt outputs are low.
- R2: While global configuration bit 0 (run) is 1, the counter increases by exactly one per clock.
- R3: While run is 0, the counter holds its value.
- R4: The counter is read and written as two 32-bit halves, low at word 4 and high at word 5, and a carry out of the low half increments the high half.
- R5: A channel with enable (configuration bit 0) set fires a pulse when the counter equals its comparator. The pulse appears one clock later, in the same clock in which the counter reads comparator+1.
- R6: In one-shot mode (configuration bit 1 clear) a channel fires once and does not fire again until a comparator half is rewritten.
- R7: In periodic mode (bit 1 set) every match adds the period to the comparator, so the pulses are spaced exactly one period apart.
- R8: With set-value (bit 2) written as 1, the next comparator write loads the comparator and the one after it loads the period.
- R9: The set-value sequence ends after the period write, or when the configuration is written with bit 2 clear. After that, comparator writes load the comparator again.
- R10: A channel with enable clear produces no pulse, and the counter keeps running.
- R11: When global configuration bit 1 (legacy) is set, channel 0 pulses appear on legacy output 0 and not on the routed lines. When it is clear, a channel pulses the line given by its route field (configuration bits 5:4).
- R12: With 32-bit mode (configuration bit 3) set, only the low 32 counter bits are compared. Otherwise all 64 bits must match.

Channel n occupies words 8+4n (configuration), 9+4n (comparator low) and 10+4n (comparator high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Word address of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_o | output | 4 | Routed interrupt lines, one-cycle pulses |
| irq_legacy_o | output | 2 | Dedicated lines for channels 0 and 1 under legacy steering |

## Verification
The assertions assume that a comparator match only matters in the clock where software does not rewrite the same channel, and that at most one register is written per cycle. The bench keeps to this by stopping the counter, or by placing comparators well ahead of it, before it reprograms a channel. It writes only on a single-cycle strobe driven at the falling edge. Pulse timing is checked by reading the counter in the cycle in which the pulse is seen, so the checks do not depend on counting the setup writes.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int CW = 64;

    localparam logic [AW-1:0] A_IDENT  = 6'h00;
    localparam logic [AW-1:0] A_TICK   = 6'h01;
    localparam logic [AW-1:0] A_GCFG   = 6'h02;
    localparam logic [AW-1:0] A_CNT_LO = 6'h04;
    localparam logic [AW-1:0] A_CNT_HI = 6'h05;
    localparam int            CH_BASE  = 8;
    localparam int            CH_STEP  = 4;

    localparam int B_EN  = 0;
    localparam int B_PER = 1;
    localparam int B_SV  = 2;
    localparam int B_M32 = 3;
    localparam int B_RT  = 4;

    typedef enum logic [1:0] {SV_IDLE, SV_CMP, SV_PER} sv_t;
endpackage

// File: rtl/evt_counter.sv
module evt_counter
    import evt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gcfg_we,
    input  logic          lo_we,
    input  logic          hi_we,
    input  logic [DW-1:0] wdata,
    output logic          run_o,
    output logic          legacy_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic          run;
        logic          legacy;
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (gcfg_we) begin
            st_d.run    = wdata[0];
            st_d.legacy = wdata[1];
        end
        if (lo_we)
            st_d.cnt[31:0] = wdata;
        else if (hi_we)
            st_d.cnt[63:32] = wdata;
        else if (st_q.run)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o    = st_q.run;
    assign legacy_o = st_q.legacy;
    assign count_o  = st_q.cnt;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run_o && !lo_we && !hi_we |=> count_o == $past(count_o) + 1'b1); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o && !lo_we && !hi_we |=> $stable(count_o)); // R3
endmodule

// File: rtl/evt_channel.sv
module evt_channel
    import evt_pkg::*;
#(
    parameter int RW = 2
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cmp_we,
    input  logic          cmp_hi,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] count,
    output logic          fire_o,
    output logic [RW-1:0] route_o,
    output logic [DW-1:0] cfg_rd_o,
    output logic [CW-1:0] cmp_rd_o
);
    typedef struct packed {
        logic          en;
        logic          per;
        logic          m32;
        logic [RW-1:0] route;
        sv_t           sv;
        logic          armed;
        logic [CW-1:0] cmp;
        logic [CW-1:0] step;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   hit;

    always_comb begin
        st_d = st_q;
        hit  = st_q.m32 ? (count[31:0] == st_q.cmp[31:0]) : (count == st_q.cmp);
        fire_o = st_q.en && hit && (st_q.per || st_q.armed);
        if (fire_o) begin
            if (st_q.per) begin
                if (st_q.m32)
                    st_d.cmp[31:0] = st_q.cmp[31:0] + st_q.step[31:0];
                else
                    st_d.cmp = st_q.cmp + st_q.step;
            end else begin
                st_d.armed = 1'b0;
            end
        end
        if (cfg_we) begin
            st_d.en    = wdata[B_EN];
            st_d.per   = wdata[B_PER];
            st_d.m32   = wdata[B_M32];
            st_d.route = wdata[B_RT +: RW];
            if (!wdata[B_SV])            st_d.sv = SV_IDLE;
            else if (st_q.sv == SV_IDLE) st_d.sv = SV_CMP;
        end
        if (cmp_we) begin
            if (st_q.sv == SV_PER) begin
                if (cmp_hi) st_d.step[63:32] = wdata;
                else        st_d.step[31:0]  = wdata;
                st_d.sv = SV_IDLE;
            end else begin
                if (cmp_hi) st_d.cmp[63:32] = wdata;
                else        st_d.cmp[31:0]  = wdata;
                st_d.armed = 1'b1;
                if (st_q.sv == SV_CMP) st_d.sv = SV_PER;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cmp  <= '1;
            st_q.sv   <= SV_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign route_o  = st_q.route;
    assign cmp_rd_o = st_q.cmp;
    always_comb begin
        cfg_rd_o            = '0;
        cfg_rd_o[B_EN]      = st_q.en;
        cfg_rd_o[B_PER]     = st_q.per;
        cfg_rd_o[B_SV]      = (st_q.sv != SV_IDLE);
        cfg_rd_o[B_M32]     = st_q.m32;
        cfg_rd_o[B_RT +: RW] = st_q.route;
    end

    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o && !st_q.per && !cmp_we |=> !st_q.armed); // R6
    AST_SV_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sv == SV_CMP && cmp_we && !cfg_we |=> st_q.sv == SV_PER); // R8
    AST_SV_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !wdata[B_SV] |=> st_q.sv == SV_IDLE); // R9
    AST_STEP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o && st_q.per && !cmp_we |=> $stable(st_q.step)); // R7
endmodule

// File: rtl/evt_router.sv
module evt_router #(
    parameter int N_CH  = 2,
    parameter int LINES = 4,
    parameter int RW    = 2
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     legacy,
    input  logic [N_CH-1:0]          fire,
    input  logic [N_CH-1:0][RW-1:0]  route,
    output logic [LINES-1:0]         irq_o,
    output logic [1:0]               irq_legacy_o
);
    typedef struct packed {
        logic [LINES-1:0] lines;
        logic [1:0]       leg;
    } rt_st_t;

    rt_st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        for (int n = 0; n < N_CH; n++) begin
            if (legacy && n < 2)
                st_d.leg[n] = st_d.leg[n] | fire[n];
            else
                st_d.lines[route[n]] = st_d.lines[route[n]] | fire[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o        = st_q.lines;
    assign irq_legacy_o = st_q.leg;

    AST_LEG_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        legacy && fire[0] |=> irq_legacy_o[0]); // R11
    AST_LEG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy |=> irq_legacy_o == 2'b00); // R11
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_pkg::*;
#(
    parameter int N_CH    = 2,
    parameter int LINES   = 4,
    parameter int TICK_FS = 5000000
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    reg_addr,
    input  logic          reg_we,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic [3:0]    irq_o,
    output logic [1:0]    irq_legacy_o
);
    localparam int RW = (LINES > 1) ? $clog2(LINES) : 1;

    logic                    run, legacy;
    logic [CW-1:0]           count;
    logic [N_CH-1:0]         fire;
    logic [N_CH-1:0][RW-1:0] route;
    logic [DW-1:0]           cfg_rd [N_CH];
    logic [CW-1:0]           cmp_rd [N_CH];
    logic [DW-1:0]           ident;

    assign ident = {23'd0, 1'b1, 3'd0, 5'(N_CH - 1)};

    evt_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .gcfg_we  (reg_we && reg_addr == A_GCFG),
        .lo_we    (reg_we && reg_addr == A_CNT_LO),
        .hi_we    (reg_we && reg_addr == A_CNT_HI),
        .wdata    (reg_wdata),
        .run_o    (run),
        .legacy_o (legacy),
        .count_o  (count)
    );

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        localparam logic [AW-1:0] A_CFG = AW'(CH_BASE + CH_STEP * k);
        localparam logic [AW-1:0] A_LO  = AW'(CH_BASE + CH_STEP * k + 1);
        localparam logic [AW-1:0] A_HI  = AW'(CH_BASE + CH_STEP * k + 2);
        evt_channel #(.RW(RW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (reg_we && reg_addr == A_CFG),
            .cmp_we   (reg_we && (reg_addr == A_LO || reg_addr == A_HI)),
            .cmp_hi   (reg_addr == A_HI),
            .wdata    (reg_wdata),
            .count    (count),
            .fire_o   (fire[k]),
            .route_o  (route[k]),
            .cfg_rd_o (cfg_rd[k]),
            .cmp_rd_o (cmp_rd[k])
        );
    end

    evt_router #(.N_CH(N_CH), .LINES(LINES), .RW(RW)) u_rt (
        .clk          (clk),
        .rst_n        (rst_n),
        .legacy       (legacy),
        .fire         (fire),
        .route        (route),
        .irq_o        (irq_o),
        .irq_legacy_o (irq_legacy_o)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_IDENT:  reg_rdata = ident;
            A_TICK:   reg_rdata = 32'(TICK_FS);
            A_GCFG:   reg_rdata = {30'd0, legacy, run};
            A_CNT_LO: reg_rdata = count[31:0];
            A_CNT_HI: reg_rdata = count[63:32];
            default:  reg_rdata = '0;
        endcase
        for (int k = 0; k < N_CH; k++) begin
            if (reg_addr == AW'(CH_BASE + CH_STEP * k))     reg_rdata = cfg_rd[k];
            if (reg_addr == AW'(CH_BASE + CH_STEP * k + 1)) reg_rdata = cmp_rd[k][31:0];
            if (reg_addr == AW'(CH_BASE + CH_STEP * k + 2)) reg_rdata = cmp_rd[k][63:32];
        end
    end

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[0] && !fire[0] && !fire[1] |=> !irq_o[0]); // R5
endmodule

// File: tb/test_evt_timer.sv
module test_evt_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_o;
    logic [1:0]  irq_legacy_o;
    logic [5:0]  irqs;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [5:0] IDENT = 0, TICK = 1, GCFG = 2, CLO = 4, CHI = 5;
    localparam logic [5:0] C0_CFG = 8,  C0_LO = 9,  C0_HI = 10;
    localparam logic [5:0] C1_CFG = 12, C1_LO = 13;
    localparam logic [31:0] EN = 1, PER = 2, SV = 4, M32 = 8;

    always #2.5 clk = ~clk;
    assign irqs = {irq_legacy_o, irq_o};

    evt_timer i_evt_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .irq_legacy_o(irq_legacy_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic wait_pulse(input int b, input int tmo, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < tmo && !seen; i++) begin
            @(negedge clk);
            if (irqs[b]) seen = 1'b1;
        end
    endtask

    task automatic count_pulses(input int b, input int cyc, output int n);
        n = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (irqs[b]) n++;
        end
    endtask

    task automatic halt_all(input logic [31:0] g);
        wr(GCFG, g);
        wr(C0_CFG, 0);
        wr(C1_CFG, 0);
        wr(CLO, 0);
        wr(CHI, 0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(IDENT, v); chk("R1 ident", v, 32'h101);
        rd(TICK, v);  chk("R1 tick", v, 32'd5000000);
        rd(GCFG, v);  chk("R1 gcfg", v, 0);
        rd(CLO, v);   chk("R1 count", v, 0);
        chk("R1 irqs", irqs, 0);
    endtask

    task automatic t_run_stop;
        logic [31:0] a, b;
        halt_all(0);
        wr(GCFG, 1);
        rd(CLO, a); repeat (10) @(negedge clk); rd(CLO, b);
        chk("R2 step", b - a, 10);
        wr(GCFG, 0);
        rd(CLO, a); repeat (10) @(negedge clk); rd(CLO, b);
        chk("R3 hold", b, a);
    endtask

    task automatic t_halves;
        logic [31:0] v;
        halt_all(0);
        wr(CHI, 5); wr(CLO, 32'hFFFF_FFFE);
        rd(CHI, v); chk("R4 hi write", v, 5);
        rd(CLO, v); chk("R4 lo write", v, 32'hFFFF_FFFE);
        wr(GCFG, 1);
        repeat (5) @(negedge clk);
        wr(GCFG, 0);
        rd(CHI, v); chk("R4 carry", v, 6);
    endtask

    task automatic t_oneshot;
        logic [31:0] v; bit seen; int n;
        halt_all(0);
        wr(C0_CFG, EN | M32 | (2 << 4));
        wr(C0_LO, 20);
        wr(GCFG, 1);
        wait_pulse(2, 100, seen);
        chk("R5 fired", seen, 1);
        rd(CLO, v); chk("R5 timing", v, 21);
        count_pulses(2, 100, n);
        chk("R6 no refire", n, 0);
    endtask

    task automatic t_periodic;
        logic [31:0] v; bit seen;
        halt_all(0);
        wr(C1_CFG, EN | PER | SV | M32 | (3 << 4));
        wr(C1_LO, 10);
        wr(C1_LO, 7);
        wr(GCFG, 1);
        for (int p = 0; p < 3; p++) begin
            wait_pulse(3, 60, seen);
            chk("R8 pulse seen", seen, 1);
            rd(CLO, v);
            chk("R7 spacing", v, 11 + 7 * p);
        end
        halt_all(0);
    endtask

    task automatic t_sv_seq;
        logic [31:0] v;
        halt_all(0);
        wr(C1_CFG, SV);
        wr(C1_CFG, 0);
        wr(C1_LO, 32'h55);
        rd(C1_LO, v); chk("R9 cancel", v, 32'h55);
        wr(C1_CFG, SV);
        wr(C1_LO, 32'hA0);
        wr(C1_LO, 32'hB0);
        rd(C1_LO, v); chk("R8 second is period", v, 32'hA0);
        rd(C1_CFG, v); chk("R9 sv cleared", v[2], 0);
        wr(C1_LO, 32'hC0);
        rd(C1_LO, v); chk("R9 back to cmp", v, 32'hC0);
    endtask

    task automatic t_disabled;
        logic [31:0] a; int n;
        halt_all(0);
        wr(C0_CFG, M32);
        wr(C0_LO, 15);
        wr(GCFG, 1);
        count_pulses(0, 60, n);
        chk("R10 silent", n, 0);
        rd(CLO, a);
        chk("R10 counter runs", a > 40, 1);
    endtask

    task automatic t_legacy;
        int nl, nr, n0;
        halt_all(2);
        wr(C0_CFG, EN | M32 | (1 << 4));
        wr(C0_LO, 25);
        wr(GCFG, 3);
        nl = 0; nr = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (irqs[4]) nl++;
            if (irqs[1]) nr++;
        end
        chk("R11 legacy line", nl, 1);
        chk("R11 routed quiet", nr, 0);
        halt_all(0);
        wr(C0_CFG, EN | M32 | (1 << 4));
        wr(C0_LO, 25);
        wr(GCFG, 1);
        count_pulses(1, 60, n0);
        chk("R11 routed line", n0, 1);
    endtask

    task automatic t_width;
        logic [31:0] v; bit seen; int n;
        halt_all(0);
        wr(CHI, 3);
        wr(C0_CFG, EN | M32);
        wr(C0_HI, 0); wr(C0_LO, 30);
        wr(GCFG, 1);
        wait_pulse(0, 100, seen);
        chk("R12 low match", seen, 1);
        rd(CLO, v); chk("R12 timing", v, 31);
        halt_all(0);
        wr(CHI, 3);
        wr(C0_CFG, EN);
        wr(C0_HI, 0); wr(C0_LO, 30);
        wr(GCFG, 1);
        count_pulses(0, 80, n);
        chk("R12 full width", n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_run_stop;
        t_halves;
        t_oneshot;
        t_periodic;
        t_sv_seq;
        t_disabled;
        t_legacy;
        t_width;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule